// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry Output

This block reshapes the second source register of an arithmetic or logic instruction before that value enters the ALU. An instruction can leave the operand alone or move it by a constant distance of 0 to 31 in one of four ways: shift left with zero fill, shift right with zero fill, shift right with sign fill, or rotate right. A fifth form rotates the operand right by exactly one place through the carry flag, so the incoming carry becomes the new top bit. For example, an add that asks for a left shift of 4 receives the second operand multiplied by sixteen.

Besides the reshaped word, the block returns a carry bit for instructions that update the flags. This carry is the last bit pushed out of the word. When nothing moves, the incoming carry passes through unchanged. The datapath is purely combinational and holds no state, so its outputs follow its inputs within the same cycle.

Top module: `opshift_unit`

## Requirements
- R1: `kind_i` selects the operation: 2'b00 shift left, 2'b01 logical shift right, 2'b10 arithmetic shift right, 2'b11 rotate right. Outputs depend only on the present inputs, with no clock or stored state.
- R2: When `dist_i` is 0 and the rotate-with-carry form is not selected, `word_o` equals `word_i` and `cout_o` equals `cin_i`, for every value of `kind_i`.
- R3: A left shift by n (1..31) gives `word_i << n`, with the n low bits zero, and `cout_o` = `word_i[32-n]`.
- R4: A logical right shift by n (1..31) gives `word_i >> n`, with the n top bits zero, and `cout_o` = `word_i[n-1]`.
- R5: An arithmetic right shift by n (1..31) fills the n top bits with copies of `word_i[31]`, and `cout_o` = `word_i[n-1]`.
- R6: A rotate right by n (1..31) moves bit i to position (i-n) mod 32 and keeps the number of set bits, and `cout_o` = `word_i[n-1]`.
- R7: With `kind_i` = 2'b11 and `xtnd_i` = 1, the result is `{cin_i, word_i[31:1]}` and `cout_o` = `word_i[0]`. `dist_i` has no effect in this form.
- R8: `xtnd_i` has no effect on either output when `kind_i` is not 2'b11.
- R9: The largest distance, 31, leaves one bit for the shifts (bit 31 moved to bit 0 for the right shifts, bit 0 moved to bit 31 for the left shift) and gives a carry from the bit next to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 32 | Second source operand before reshaping |
| kind_i | input | 2 | Operation select (encoding in R1) |
| dist_i | input | 5 | Constant shift or rotate distance |
| xtnd_i | input | 1 | Turns rotate right into rotate by one through carry |
| cin_i | input | 1 | Current carry flag |
| word_o | output | 32 | Reshaped operand for the ALU |
| cout_o | output | 1 | Carry produced by the reshaping |

## Verification
The immediate assertions assume that every input is a known 0 or 1 once the inputs settle, and that `dist_i` never exceeds 31. The 5-bit port already enforces the second assumption. The bench drives only fully specified values at the falling clock edge and samples a few nanoseconds later, after the combinational paths have settled. Its pseudo-random sweep draws operands, kinds, distances and both flag inputs from a register-width LFSR, so no input bit is ever left unknown.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'b00,
    SK_LOGR  = 2'b01,
    SK_ARIR  = 2'b10,
    SK_ROTR  = 2'b11
  } shift_kind_e;

  // Left shift by a variable distance; carry is the last bit leaving the top.
  function automatic logic [32:0] left_fn(input logic [31:0] x, input logic [4:0] n, input logic c);
    logic [31:0] r;
    logic        k;
    r = x << n;
    k = (n == 5'd0) ? c : x[6'd32 - {1'b0, n}];
    return {k, r};
  endfunction

  // Right shift, zero or sign fill; carry is the last bit leaving the bottom.
  function automatic logic [32:0] right_fn(input logic [31:0] x, input logic [4:0] n,
                                           input logic c, input logic arith);
    logic [31:0] r;
    logic        k;
    if (arith) r = $unsigned($signed(x) >>> n);
    else       r = x >> n;
    k = (n == 5'd0) ? c : x[n - 5'd1];
    return {k, r};
  endfunction

endpackage

// File: rtl/opshift_left.sv
module opshift_left #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] n_i,
  input  logic          c_i,
  output logic [W-1:0]  r_o,
  output logic          k_o
);
  import opshift_pkg::*;

  logic [32:0] packed_res;
  logic [W-1:0] low_mask;

  assign packed_res = left_fn(x_i, n_i, c_i);
  assign r_o        = packed_res[W-1:0];
  assign k_o        = packed_res[W];
  assign low_mask   = ~({W{1'b1}} << n_i);

  always_comb begin
    a_r3_low_bits_zero: assert ((r_o & low_mask) == '0);
    if (n_i == '0) begin
      a_r2_left_carry_pass: assert (k_o == c_i && r_o == x_i);
    end
  end
endmodule

// File: rtl/opshift_right.sv
module opshift_right #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] n_i,
  input  logic          c_i,
  input  logic          arith_i,
  output logic [W-1:0]  r_o,
  output logic          k_o
);
  import opshift_pkg::*;

  logic [32:0]  packed_res;
  logic [W-1:0] top_mask;
  logic         fill_bit;

  assign packed_res = right_fn(x_i, n_i, c_i, arith_i);
  assign r_o        = packed_res[W-1:0];
  assign k_o        = packed_res[W];
  assign top_mask   = ~({W{1'b1}} >> n_i);
  assign fill_bit   = arith_i & x_i[W-1];

  always_comb begin
    a_r4_r5_fill: assert ((r_o & top_mask) == (fill_bit ? top_mask : '0));
    if (arith_i) begin
      a_r5_sign_kept: assert (r_o[W-1] == x_i[W-1]);
    end
  end
endmodule

// File: rtl/opshift_rotate.sv
module opshift_rotate #(
  parameter int W = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] n_i,
  input  logic          c_i,
  input  logic          xtnd_i,
  output logic [W-1:0]  r_o,
  output logic          k_o
);
  logic [W-1:0] stage [AW+1];
  logic [W-1:0] rot_word;
  logic         rot_carry;
  logic [W-1:0] ext_word;
  logic         ext_carry;

  assign stage[0] = x_i;

  // Logarithmic rotator: stage s rotates by 2**s when distance bit s is set.
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = n_i[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]} : stage[s];
  end

  assign rot_word  = stage[AW];
  assign rot_carry = (n_i == '0) ? c_i : rot_word[W-1];
  assign ext_word  = {c_i, x_i[W-1:1]};
  assign ext_carry = x_i[0];

  assign r_o = xtnd_i ? ext_word  : rot_word;
  assign k_o = xtnd_i ? ext_carry : rot_carry;

  always_comb begin
    a_r6_ones_kept: assert ($countones(rot_word) == $countones(x_i));
    if (xtnd_i) begin
      a_r7_carry_in_top: assert (r_o[W-1] == c_i && k_o == x_i[0]);
    end
  end
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit (
  input  logic [31:0] word_i,
  input  logic [1:0]  kind_i,
  input  logic [4:0]  dist_i,
  input  logic        xtnd_i,
  input  logic        cin_i,
  output logic [31:0] word_o,
  output logic        cout_o
);
  import opshift_pkg::*;

  localparam int W = 32;

  shift_kind_e  kind;
  logic [W-1:0] left_r,  right_r,  rot_r;
  logic         left_k,  right_k,  rot_k;
  logic         rot_xtnd;

  assign kind     = shift_kind_e'(kind_i);
  assign rot_xtnd = xtnd_i & (kind == SK_ROTR);

  opshift_left #(.W(W)) u_left (
    .x_i(word_i), .n_i(dist_i), .c_i(cin_i), .r_o(left_r), .k_o(left_k)
  );

  opshift_right #(.W(W)) u_right (
    .x_i(word_i), .n_i(dist_i), .c_i(cin_i), .arith_i(kind == SK_ARIR),
    .r_o(right_r), .k_o(right_k)
  );

  opshift_rotate #(.W(W)) u_rot (
    .x_i(word_i), .n_i(dist_i), .c_i(cin_i), .xtnd_i(rot_xtnd),
    .r_o(rot_r), .k_o(rot_k)
  );

  always_comb begin
    unique case (kind)
      SK_LEFT:          begin word_o = left_r;  cout_o = left_k;  end
      SK_LOGR, SK_ARIR: begin word_o = right_r; cout_o = right_k; end
      default:          begin word_o = rot_r;   cout_o = rot_k;   end
    endcase
  end

  always_comb begin
    if (dist_i == 5'd0 && !rot_xtnd) begin
      a_r2_identity: assert (word_o == word_i && cout_o == cin_i);
    end
    if (kind != SK_ROTR) begin
      a_r8_no_extend: assert (rot_xtnd == 1'b0);
    end
  end
endmodule

// File: tb/opshift_unit_test.sv
module opshift_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] word_i;
  logic [1:0]  kind_i;
  logic [4:0]  dist_i;
  logic        xtnd_i, cin_i;
  logic [31:0] word_o;
  logic        cout_o;

  int n_checks = 0;
  int n_fail   = 0;

  opshift_unit uut (
    .word_i(word_i), .kind_i(kind_i), .dist_i(dist_i), .xtnd_i(xtnd_i),
    .cin_i(cin_i), .word_o(word_o), .cout_o(cout_o)
  );

  // Reference built from wide concatenations, not from the RTL structure.
  function automatic logic [32:0] model(input logic [31:0] x, input logic [1:0] k,
                                        input logic [4:0] n, input logic c, input logic e);
    logic [63:0]        tl;
    logic [32:0]        tr;
    logic signed [33:0] ta;
    logic [64:0]        tq;
    case (k)
      2'b00: begin tl = {32'b0, x} << n; return {(n == 0) ? c : tl[32], tl[31:0]}; end
      2'b01: begin tr = {x, 1'b0} >> n;  return {(n == 0) ? c : tr[0], tr[32:1]}; end
      2'b10: begin ta = $signed({x[31], x, 1'b0}) >>> n;
                   return {(n == 0) ? c : ta[0], ta[32:1]}; end
      default: begin
        if (e) return {x[0], c, x[31:1]};
        tq = {x, x, 1'b0} >> n;
        return {(n == 0) ? c : tq[0], tq[32:1]};
      end
    endcase
  endfunction

  task automatic apply(input string tag, input logic [31:0] x, input logic [1:0] k,
                       input logic [4:0] n, input logic c, input logic e);
    logic [32:0] exp;
    @(negedge clk);
    word_i = x; kind_i = k; dist_i = n; cin_i = c; xtnd_i = e;
    #3;
    exp = model(x, k, n, c, e);
    n_checks++;
    if (word_o !== exp[31:0] || cout_o !== exp[32]) begin
      n_fail++;
      $display("FAIL %s: x=%h kind=%0d n=%0d c=%0b e=%0b actual=%h/%0b expected=%h/%0b",
               tag, x, k, n, c, e, word_o, cout_o, exp[31:0], exp[32]);
    end
  endtask

  task automatic t_idle_state;
    apply("R1 idle", 32'h0, 2'b00, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_dist;
    for (int k = 0; k < 4; k++) begin
      apply("R2 zero distance", 32'hA5C3_0F81, 2'(k), 5'd0, 1'b1, 1'b0);
      apply("R2 zero distance", 32'h1234_5678, 2'(k), 5'd0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_left;
    apply("R3 left by 4", 32'h0000_0007, 2'b00, 5'd4, 1'b0, 1'b0);
    apply("R3 left carry", 32'h9000_0001, 2'b00, 5'd1, 1'b0, 1'b0);
    apply("R3 left mid", 32'hF0F0_1234, 2'b00, 5'd13, 1'b1, 1'b0);
  endtask

  task automatic t_logical_right;
    apply("R4 right zero fill", 32'h8000_0000, 2'b01, 5'd4, 1'b0, 1'b0);
    apply("R4 right carry", 32'h0000_0018, 2'b01, 5'd4, 1'b0, 1'b0);
    apply("R4 right mid", 32'hFFFF_FFFF, 2'b01, 5'd17, 1'b0, 1'b0);
  endtask

  task automatic t_arith_right;
    apply("R5 sign fill neg", 32'h8000_0010, 2'b10, 5'd5, 1'b0, 1'b0);
    apply("R5 sign fill pos", 32'h7FFF_FFF0, 2'b10, 5'd5, 1'b1, 1'b0);
    apply("R5 neg mid", 32'hC000_0001, 2'b10, 5'd1, 1'b0, 1'b0);
  endtask

  task automatic t_rotate;
    apply("R6 rotate 8", 32'h1122_3344, 2'b11, 5'd8, 1'b0, 1'b0);
    apply("R6 rotate carry", 32'h0000_0001, 2'b11, 5'd1, 1'b0, 1'b0);
    apply("R6 rotate 16", 32'hDEAD_BEEF, 2'b11, 5'd16, 1'b1, 1'b0);
  endtask

  task automatic t_extend;
    apply("R7 extend c=1", 32'h0000_0002, 2'b11, 5'd0, 1'b1, 1'b1);
    apply("R7 extend c=0", 32'hFFFF_FFFF, 2'b11, 5'd9, 1'b0, 1'b1);
    apply("R7 extend dist ignored", 32'h8765_4321, 2'b11, 5'd31, 1'b1, 1'b1);
  endtask

  task automatic t_extend_ignored;
    for (int k = 0; k < 3; k++) begin
      apply("R8 extend ignored", 32'hC3A5_5A3C, 2'(k), 5'd3, 1'b1, 1'b1);
      apply("R8 extend ignored n0", 32'h0000_0001, 2'(k), 5'd0, 1'b0, 1'b1);
    end
  endtask

  task automatic t_max_dist;
    apply("R9 left 31", 32'h0000_0003, 2'b00, 5'd31, 1'b0, 1'b0);
    apply("R9 logical 31", 32'hC000_0000, 2'b01, 5'd31, 1'b0, 1'b0);
    apply("R9 arith 31", 32'hC000_0000, 2'b10, 5'd31, 1'b0, 1'b0);
    apply("R9 rotate 31", 32'h8000_0001, 2'b11, 5'd31, 1'b0, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr = 32'h1D87_2B41;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply("R1 sweep", lfsr ^ (lfsr << 7), lfsr[1:0], lfsr[8:4], lfsr[10], lfsr[12]);
    end
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    word_i = '0; kind_i = '0; dist_i = '0; xtnd_i = 1'b0; cin_i = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle_state();
    t_zero_dist();
    t_left();
    t_logical_right();
    t_arith_right();
    t_rotate();
    t_extend();
    t_extend_ignored();
    t_max_dist();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule